// File: doc/BRIEF.md
# Power-Mode-Aware Clock Output Selector

This block drives a single clock output pin from one of nine derived clocks. Four come from the system clock divided by 32, 16, 8 or 4, four from the low-speed watch clock divided by the same ratios, and the ninth is the undivided watch clock. A small selection register holds a 3-bit source field, a bypass bit that picks the undivided watch clock, and an output enable. The register changes only on a write strobe.

Both source clocks reach the block as edge strobes in a single fast clock domain. `sysTick` and `watchTick` each pulse once for every half-period of their source. Each strobe advances its own 6-bit ripple-style phase counter. Bit 0 of a counter is the undivided source clock and bit k is the source divided by 2^k.

The pin is registered. It is held low when the enable is clear, during reset, and whenever the chosen source's clock domain is stopped in the present power mode, which arrives on `pwrMode`. The phase counters keep running while the pin is gated, so the output comes back in phase with its source when the gating ends.

Top module: `clkout_sel`

## Requirements
- R1: While `rstN` is low, `clkOut` is 0 and the source field, bypass bit, output enable and both phase counters are cleared to 0.
- R2: The source field, bypass bit and enable load from `wrField`, `wrAlt` and `wrOe` only in a cycle with `wrEn` = 1. With `wrEn` = 0, changes on those inputs have no effect on `clkOut`.
- R3: With the stored enable at 0, `clkOut` is 0 whatever the source and mode.
- R4: With bypass 0, field values 0, 1, 2 and 3 select the system clock divided by 32, 16, 8 and 4, which are system phase counter bits 5, 4, 3 and 2.
- R5: With bypass 0, field values 4, 5, 6 and 7 select the watch clock divided by 32, 16, 8 and 4, which are watch phase counter bits 5, 4, 3 and 2.
- R6: With bypass 1, the undivided watch clock (watch phase counter bit 0) is selected, whatever the field holds.
- R7: System-clock sources reach the pin only when `pwrMode` is 0 (active) or 1 (sleep). In any other mode the pin is 0.
- R8: Divided watch-clock sources reach the pin when `pwrMode` is 0 (active), 1 (sleep), 2 (watch), 3 (subactive) or 4 (subsleep). When `pwrMode` is 5 (standby), 6 or 7, the pin is 0.
- R9: The undivided watch clock reaches the pin in every `pwrMode` code 0 to 7. Only reset and the enable can stop it.
- R10: `clkOut` is registered. Its value in a cycle is computed from the register contents, phase counters and `pwrMode` as they stood before the preceding clock edge.
- R11: Each phase counter advances by exactly one, modulo 64, in every cycle in which its tick is 1, and holds otherwise. This applies in every power mode, gated or not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sysTick | input | 1 | One pulse per system-clock half-period |
| watchTick | input | 1 | One pulse per watch-clock half-period |
| pwrMode | input | 3 | Power mode: 0 active, 1 sleep, 2 watch, 3 subactive, 4 subsleep, 5 standby, 6-7 treated as standby |
| wrEn | input | 1 | Write strobe for the selection register |
| wrField | input | 3 | Source field to load |
| wrAlt | input | 1 | Bypass bit to load (1 selects undivided watch clock) |
| wrOe | input | 1 | Output enable to load |
| clkOut | output | 1 | Selected, gated clock output |

## Verification
The hardest situation to reach is a mode change in the middle of a long divide period. It must show that the pin drops at once but the hidden phase counter keeps counting, so that the output resumes at the correct phase rather than restarting. The stimulus runs the /32 taps for several full periods with dense and sparse tick patterns. It then switches into modes that stop the selected domain partway through a half-period, keeps ticking there, and switches back. The cycle-accurate reference then exposes any counter that froze or cleared while gated.

// File: rtl/clkout_sel_pkg.sv
package clkout_sel_pkg;

  typedef enum logic [2:0] {
    PM_ACTIVE    = 3'd0,
    PM_SLEEP     = 3'd1,
    PM_WATCH     = 3'd2,
    PM_SUBACTIVE = 3'd3,
    PM_SUBSLEEP  = 3'd4,
    PM_STANDBY   = 3'd5
  } pwrMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       gateOpen;   // chosen source may reach the pin
    logic       fromWatch;  // divided taps come from the watch chain
    logic       rawWatch;   // bypass: undivided watch clock
    logic [1:0] tapIdx;     // 0 -> /32 ... 3 -> /4
  } outCtl_t;

endpackage

// File: rtl/clkout_divchain.sv
module clkout_divchain #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  output logic [CNT_W-1:0] phase
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else if (tick) phase <= phase + ONE;
  end

  // R11
  phase_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> phase == $past(phase) + ONE);

  // R11
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(phase));

endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
  import clkout_sel_pkg::*;
#(
  parameter int FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         pwrMode,
  input  logic               wrEn,
  input  logic [FIELD_W-1:0] wrField,
  input  logic               wrAlt,
  input  logic               wrOe,
  output outCtl_t            ctl
);

  logic [FIELD_W-1:0] selField;
  logic               selAlt;
  logic               selOe;
  pwrMode_e           modeNow;
  logic               sysAvail;
  logic               watchDivAvail;
  logic               srcAvail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selField <= '0;
      selAlt   <= 1'b0;
      selOe    <= 1'b0;
    end else if (wrEn) begin
      selField <= wrField;
      selAlt   <= wrAlt;
      selOe    <= wrOe;
    end
  end

  always_comb begin
    modeNow       = pwrMode_e'(pwrMode);
    sysAvail      = (modeNow == PM_ACTIVE) || (modeNow == PM_SLEEP);
    watchDivAvail = (pwrMode <= 3'(PM_SUBSLEEP));
    if (selAlt)                 srcAvail = 1'b1;
    else if (selField[FIELD_W-1]) srcAvail = watchDivAvail;
    else                        srcAvail = sysAvail;
    ctl.gateOpen  = selOe && srcAvail;
    ctl.fromWatch = selField[FIELD_W-1];
    ctl.rawWatch  = selAlt;
    ctl.tapIdx    = selField[1:0];
  end

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable({selField, selAlt, selOe}));

  // R7
  sys_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.gateOpen && !ctl.rawWatch && !ctl.fromWatch) |-> (pwrMode < 3'd2));

  // R3
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !selOe |-> !ctl.gateOpen);

endmodule

// File: rtl/clkout_dpath.sv
module clkout_dpath
  import clkout_sel_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int TAP_N = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sysTick,
  input  logic    watchTick,
  input  outCtl_t ctl,
  output logic    clkOut
);

  localparam int SRC_N = 2;

  logic [SRC_N-1:0] srcTick;
  logic [CNT_W-1:0] srcPhase [SRC_N];
  logic [TAP_N-1:0] sysTaps;
  logic [TAP_N-1:0] watchTaps;
  logic             divPick;
  logic             nextOut;

  assign srcTick = {watchTick, sysTick};

  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    clkout_divchain #(.CNT_W(CNT_W)) u_chain (
      .clk   (clk),
      .rstN  (rstN),
      .tick  (srcTick[s]),
      .phase (srcPhase[s])
    );
  end

  // tap i divides by 2^(CNT_W-1-i)
  for (genvar i = 0; i < TAP_N; i++) begin : g_tap
    assign sysTaps[i]   = srcPhase[0][CNT_W-1-i];
    assign watchTaps[i] = srcPhase[1][CNT_W-1-i];
  end

  always_comb begin
    divPick = ctl.fromWatch ? watchTaps[ctl.tapIdx] : sysTaps[ctl.tapIdx];
    if (!ctl.gateOpen)    nextOut = 1'b0;
    else if (ctl.rawWatch) nextOut = srcPhase[1][0];
    else                  nextOut = divPick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkOut <= 1'b0;
    else       clkOut <= nextOut;
  end

  // R3
  gate_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.gateOpen |=> !clkOut);

  // R6
  raw_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.gateOpen && ctl.rawWatch) |=> clkOut == $past(srcPhase[1][0]));

  // R10
  out_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkOut |-> $past(ctl.gateOpen));

endmodule

// File: rtl/clkout_sel.sv
module clkout_sel
  import clkout_sel_pkg::*;
#(
  parameter int DIV_LOG2_MAX = 5,
  parameter int FIELD_W      = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sysTick,
  input  logic               watchTick,
  input  logic [2:0]         pwrMode,
  input  logic               wrEn,
  input  logic [FIELD_W-1:0] wrField,
  input  logic               wrAlt,
  input  logic               wrOe,
  output logic               clkOut
);

  localparam int CNT_W = DIV_LOG2_MAX + 1;
  localparam int TAP_N = 1 << (FIELD_W - 1);

  outCtl_t ctl;

  clkout_ctrl #(.FIELD_W(FIELD_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pwrMode (pwrMode),
    .wrEn    (wrEn),
    .wrField (wrField),
    .wrAlt   (wrAlt),
    .wrOe    (wrOe),
    .ctl     (ctl)
  );

  clkout_dpath #(.CNT_W(CNT_W), .TAP_N(TAP_N)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .sysTick   (sysTick),
    .watchTick (watchTick),
    .ctl       (ctl),
    .clkOut    (clkOut)
  );

endmodule

// File: tb/sim_clkout_sel.sv
`timescale 1ns/1ps
module sim_clkout_sel;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sysTick = 1'b0;
  logic       watchTick = 1'b0;
  logic [2:0] pwrMode = 3'd0;
  logic       wrEn = 1'b0;
  logic [2:0] wrField = 3'd0;
  logic       wrAlt = 1'b0;
  logic       wrOe = 1'b0;
  logic       clkOut;

  int vectors = 0;
  int misses = 0;
  int cyc = 0;
  bit started = 0;
  string focus = "";

  // reference state
  int mSys = 0, mWatch = 0, mField = 0;
  bit mAlt = 0, mOe = 0, mExp = 0;

  always #2 clk = ~clk;

  clkout_sel u0 (
    .clk(clk), .rstN(rstN), .sysTick(sysTick), .watchTick(watchTick),
    .pwrMode(pwrMode), .wrEn(wrEn), .wrField(wrField), .wrAlt(wrAlt),
    .wrOe(wrOe), .clkOut(clkOut)
  );

  function automatic bit refOut(int mode);
    if (!mOe) return 0;
    if (mAlt) return mWatch % 2;
    if (mField < 4) begin
      if (mode > 1) return 0;
      return (mSys >> (5 - mField)) % 2;
    end
    if (mode > 4) return 0;
    return (mWatch >> (5 - (mField - 4))) % 2;
  endfunction

  function automatic string tagOf();
    if (focus != "") return focus;
    if (!rstN) return "R1";
    if (!mOe) return "R3";
    if (mAlt) return (pwrMode > 4) ? "R9" : "R6";
    if (mField < 4) return (pwrMode > 1) ? "R7" : "R4";
    return (pwrMode > 4) ? "R8" : "R5";
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rstN) begin
      mSys = 0; mWatch = 0; mField = 0; mAlt = 0; mOe = 0; mExp = 0;
    end else begin
      mExp = refOut(int'(pwrMode));
      if (wrEn) begin
        mField = int'(wrField); mAlt = wrAlt; mOe = wrOe;
      end
      if (sysTick)   mSys   = (mSys + 1) % 64;
      if (watchTick) mWatch = (mWatch + 1) % 64;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      vectors++;
      if (clkOut !== mExp) begin
        misses++;
        $display("FAIL %s at cycle %0d: clkOut actual=%b expected=%b",
                 tagOf(), cyc, clkOut, mExp);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      misses++;
      $display("FAIL watchdog: cycles actual=%0d expected<=200000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic write(input int f, input bit a, input bit o);
    @(negedge clk);
    wrEn = 1; wrField = 3'(f); wrAlt = a; wrOe = o;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic run(input int n, input int sysPct, input int watchPct);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sysTick   = ($urandom_range(99) < sysPct);
      watchTick = ($urandom_range(99) < watchPct);
    end
    @(negedge clk);
    sysTick = 0; watchTick = 0;
  endtask

  initial begin
    // R1: reset state, ticks ignored while reset is held
    focus = "R1";
    sysTick = 1; watchTick = 1;
    repeat (5) @(negedge clk);
    rstN = 1;
    sysTick = 0; watchTick = 0;
    run(4, 100, 100);
    focus = "";

    // R4: system taps in active mode, dense and sparse ticks
    pwrMode = 3'd0;
    for (int f = 0; f < 4; f++) begin
      write(f, 0, 1);
      run(200, 100, 50);
      run(150, 30, 50);
    end

    // R7: system tap gated outside active/sleep; counters keep running (R11)
    write(0, 0, 1);
    for (int m = 1; m < 8; m++) begin
      pwrMode = 3'(m);
      run(45, 100, 100);
    end
    focus = "R11";
    pwrMode = 3'd0;
    run(130, 100, 100);
    focus = "";

    // R5: watch taps
    for (int f = 4; f < 8; f++) begin
      write(f, 0, 1);
      run(200, 20, 100);
      run(100, 0, 40);
    end

    // R8: divided watch across every mode code
    write(4, 0, 1);
    for (int m = 0; m < 8; m++) begin
      pwrMode = 3'(m);
      run(50, 50, 100);
    end

    // R6 / R9: bypass ignores field, runs in every mode
    for (int f = 0; f < 8; f++) begin
      write(f, 1, 1);
      pwrMode = 3'(f);
      run(40, 60, 70);
    end

    // R3: enable clear blocks every source
    pwrMode = 3'd0;
    write(1, 1, 0);
    run(60, 100, 100);
    write(3, 0, 0);
    run(60, 100, 100);

    // R2: register inputs moving without the strobe
    focus = "R2";
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      wrField = 3'($urandom_range(7)); wrAlt = 1; wrOe = 1;
      watchTick = 1;
    end
    @(negedge clk); watchTick = 0;
    focus = "";

    // R10: output follows a write one edge late
    focus = "R10";
    write(7, 0, 1);
    run(20, 0, 100);
    write(3, 0, 1);
    run(20, 100, 0);
    focus = "";

    // mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      sysTick   = $urandom_range(1);
      watchTick = ($urandom_range(3) == 0);
      if ($urandom_range(40) == 0) pwrMode = 3'($urandom_range(7));
      wrEn = ($urandom_range(60) == 0);
      wrField = 3'($urandom_range(7));
      wrAlt = ($urandom_range(4) == 0);
      wrOe = ($urandom_range(5) != 0);
    end
    @(negedge clk); wrEn = 0;

    // R1: reset mid-run clears everything again
    focus = "R1";
    rstN = 0;
    run(3, 100, 100);
    rstN = 1;
    run(3, 0, 0);
    focus = "";

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule